// File: doc/BRIEF.md
# Signalling Slot Extraction Engine

This block watches time slot 0 of every PCM input line of a switching matrix. It hands new signalling messages to the control processor one at a time. The processor arms the engine through the command decoder by writing a line-enable mask. The mask is kept in two copies. A background copy stays fixed, and a working "pending" copy is consumed as messages are delivered.

At every frame strobe the pending copy is reloaded from the background copy. The engine then reads the slot-0 byte of each line from speech memory. Any line whose byte starts with the idle label `01` is dropped. If any lines remain, the data-ready output pulses low and the second output register announces how many messages there are.

The processor then walks the engine through the messages by reading the two output registers in turn. Each fresh read of the second register fetches the next message, taking the highest remaining line number first. The first register then holds the message byte. The second register holds the source line and a flag that tells whether more messages follow. A new frame strobe drops whatever is left and starts again from the background copy. Speech-memory work only begins when the short-command path is idle.

Top module: `sig_slot_extractor`

## Requirements
- R1: After reset, `dr_n` is 1, `or1` is 8'h00, `or2` is 8'h0E and `sm_rd_en` is 0. Frame strobes before any mask store cause no speech-memory read and no `dr_n` pulse.
- R2: A mask store with a non-zero mask updates `or2` on the next clock edge to {enabled-line count modulo 8 in bits 7..5, 1 in bit 4, 4'b1110 in bits 3..0}. `or1` is left unchanged.
- R3: A mask store with an all-zero mask sets `or2` to 8'h0E and disarms the engine. Later frame strobes then cause no speech-memory read and no `dr_n` pulse.
- R4: After a frame strobe on an armed engine, lines 0 to NLINES-1 are read once each, in ascending order, one per clock. Enabled lines whose slot-0 byte has bits 7..6 equal to 2'b01 are removed from the pending set.
- R5: The engine checks the remaining count once the scan ends. If it is non-zero, `dr_n` falls 11 clock edges after the edge that samples the strobe and stays low for exactly 2 clocks. In the same cycle `or2` becomes {count modulo 8, 1, 4'b1110}. If the count is zero, `dr_n` stays high and `or2` keeps its value.
- R6: A fresh read of `or2` (`rd_sel`=1) while messages are pending updates both registers 2 clock edges after the read is sampled. `or1` takes the slot-0 byte of the chosen line. `or2` becomes {line number in bits 7..5, more-pending flag in bit 4, 4'b1110}.
- R7: Pending lines are delivered from the highest line number to the lowest.
- R8: A read of `or2` is fresh only if the previous read was of `or1`, or if no read has happened since the announcement. Repeated `or2` reads and any `or1` read leave both registers unchanged.
- R9: A fresh `or2` read after the last message has been delivered (flag 0) starts no speech-memory read and leaves both registers unchanged.
- R10: A frame strobe while messages are still pending drops them. It restarts the scan from the background mask and announces and delivers again from the highest line.
- R11: While `short_busy` is 1, the engine starts no speech-memory access. A scan that is waiting begins on the edge that samples `short_busy` low. With that edge counted as edge 0, `dr_n` falls on edge 10.

Each `or2` value is laid out as bits 7..5 holding a count or line, bit 4 a flag, and bits 3..0 the tag 4'b1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_wr | input | 1 | One-cycle mask store from the command decoder |
| mask_data | input | NLINES (8) | Line-enable mask, bit i enables line i |
| frame_stb | input | 1 | One-cycle frame start strobe |
| short_busy | input | 1 | A short command is using speech memory |
| sm_rd_en | output | 1 | Speech-memory slot-0 read request |
| sm_rd_line | output | clog2(NLINES) (3) | Line whose slot-0 byte is read |
| sm_rd_data | input | 8 | Slot-0 byte, valid the clock after the request |
| rd_stb | input | 1 | One-cycle processor register read |
| rd_sel | input | 1 | Register read: 0 = `or1`, 1 = `or2` |
| dr_n | output | 1 | Data-ready interrupt, active low |
| or1 | output | 8 | Message byte register |
| or2 | output | 8 | Count/line, flag and tag register |
| ext_busy | output | 1 | Engine is using or about to use speech memory |

## Verification
Each result has a fixed due cycle:
- A mask store shows in `or2` on the next edge.
- The interrupt falls 11 edges after the frame strobe is sampled, or 10 edges after `short_busy` is seen low.
- A message step shows 2 edges after the `or2` read.

The bench drives every input on a falling edge and counts falling edges from the stimulus. It samples each output exactly on the falling edge after its due rising edge. It checks the interrupt width and the number and order of speech-memory reads in the same windows.

// File: rtl/sigx_pkg.sv
`timescale 1ns/1ps
package sigx_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam logic [3:0] OR2_TAG = 4'b1110;

   typedef enum logic [2:0] {
      S_IDLE, S_PEND, S_SCAN, S_DRAIN, S_FIN, S_WAIT, S_FETCH, S_CAP
   } sigx_state_e;

   function automatic logic [BYTE_W-1:0] pack_or2(input logic [2:0] fld, input logic flag);
      return {fld, flag, OR2_TAG};
   endfunction
endpackage

// File: rtl/sigx_popcnt.sv
`timescale 1ns/1ps
module sigx_popcnt #(
   parameter int unsigned N  = 8,
   parameter int unsigned CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  vec,
   output logic [CW-1:0] cnt
);
   logic [CW-1:0] part [N+1];

   assign part[0] = '0;
   for (genvar i = 0; i < N; i++) begin : g_add
      assign part[i+1] = part[i] + CW'(vec[i]);
   end
   assign cnt = part[N];
endmodule

// File: rtl/sigx_hi_pick.sv
`timescale 1ns/1ps
module sigx_hi_pick #(
   parameter int unsigned N  = 8,
   parameter int unsigned LW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [LW-1:0] idx,
   output logic          any,
   output logic          rest_any
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (vec[i]) begin
            idx = LW'(i);
            any = 1'b1;
         end
      end
      rest_any = |(vec & ~(N'(1) << idx));
   end
endmodule

// File: rtl/sigx_rd_fresh.sv
`timescale 1ns/1ps
module sigx_rd_fresh (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_stb,
   input  logic rd_sel,
   input  logic rearm,
   output logic or2_adv
);
   logic last_or2_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      last_or2_q <= 1'b0;
      else if (rearm)  last_or2_q <= 1'b0;
      else if (rd_stb) last_or2_q <= rd_sel;
   end

   assign or2_adv = rd_stb & rd_sel & ~last_or2_q;
endmodule

// File: rtl/sig_slot_extractor.sv
`timescale 1ns/1ps
module sig_slot_extractor #(
   parameter int unsigned NLINES     = 8,
   parameter int unsigned DR_CYCLES  = 2,
   parameter logic [1:0]  IDLE_LABEL = 2'b01,
   parameter bit          FRESH_ONLY = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      mask_wr,
   input  logic [NLINES-1:0]         mask_data,
   input  logic                      frame_stb,
   input  logic                      short_busy,
   output logic                      sm_rd_en,
   output logic [$clog2(NLINES)-1:0] sm_rd_line,
   input  logic [7:0]                sm_rd_data,
   input  logic                      rd_stb,
   input  logic                      rd_sel,
   output logic                      dr_n,
   output logic [7:0]                or1,
   output logic [7:0]                or2,
   output logic                      ext_busy
);
   import sigx_pkg::*;

   localparam int unsigned LW  = $clog2(NLINES);
   localparam int unsigned CW  = $clog2(NLINES + 1);
   localparam int unsigned DCW = $clog2(DR_CYCLES + 1);
   localparam logic [LW-1:0]  LAST_LINE = LW'(NLINES - 1);
   localparam logic [DCW-1:0] DR_LOAD   = DCW'(DR_CYCLES);

   if (NLINES != 2 && NLINES != 4 && NLINES != 8) begin : g_bad_lines
      $error("NLINES must be 2, 4 or 8");
   end
   if (DR_CYCLES < 1 || DR_CYCLES > 15) begin : g_bad_dr
      $error("DR_CYCLES must be 1..15");
   end

   sigx_state_e        st_q;
   logic [NLINES-1:0]  bg_q, pend_q;
   logic [LW-1:0]      scan_cnt_q, rsp_line_q, cur_line_q;
   logic               rsp_vld_q;
   logic [7:0]         or1_q, or2_q;
   logic [DCW-1:0]     dr_cnt_q;

   logic [CW-1:0]      mask_cnt, pend_cnt;
   logic [LW-1:0]      pick_idx;
   logic               pick_any, pick_rest;
   logic               or2_adv, rearm, drop_rsp;

   sigx_popcnt #(.N(NLINES), .CW(CW)) u_mask_cnt (.vec(mask_data), .cnt(mask_cnt));
   sigx_popcnt #(.N(NLINES), .CW(CW)) u_pend_cnt (.vec(pend_q),    .cnt(pend_cnt));
   sigx_hi_pick #(.N(NLINES), .LW(LW)) u_pick (
      .vec(pend_q), .idx(pick_idx), .any(pick_any), .rest_any(pick_rest)
   );

   assign rearm = (st_q == S_FIN) && (pend_q != '0);

   if (FRESH_ONLY) begin : g_fresh
      sigx_rd_fresh u_fresh (
         .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_sel(rd_sel),
         .rearm(rearm), .or2_adv(or2_adv)
      );
   end else begin : g_every
      assign or2_adv = rd_stb & rd_sel;
   end

   assign drop_rsp = rsp_vld_q && (sm_rd_data[7:6] == IDLE_LABEL);

   always_comb begin
      sm_rd_en   = (st_q == S_SCAN) || ((st_q == S_FETCH) && !short_busy);
      sm_rd_line = (st_q == S_SCAN) ? scan_cnt_q : cur_line_q;
      ext_busy   = (st_q == S_SCAN) || (st_q == S_DRAIN) || (st_q == S_FIN) ||
                   (st_q == S_FETCH) || (st_q == S_CAP);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         bg_q       <= '0;
         pend_q     <= '0;
         scan_cnt_q <= '0;
         rsp_line_q <= '0;
         cur_line_q <= '0;
         rsp_vld_q  <= 1'b0;
         or1_q      <= 8'h00;
         or2_q      <= pack_or2(3'b000, 1'b0);
         dr_cnt_q   <= '0;
      end else begin
         rsp_vld_q  <= sm_rd_en && (st_q == S_SCAN);
         rsp_line_q <= sm_rd_line;
         if (dr_cnt_q != '0) dr_cnt_q <= dr_cnt_q - 1'b1;

         if (mask_wr) begin
            bg_q   <= mask_data;
            pend_q <= mask_data;
            or2_q  <= pack_or2(3'(mask_cnt), |mask_data);
            st_q   <= S_IDLE;
         end else if (frame_stb) begin
            pend_q <= bg_q;
            st_q   <= (bg_q != '0) ? S_PEND : S_IDLE;
         end else begin
            unique case (st_q)
               S_PEND: begin
                  if (!short_busy) begin
                     st_q       <= S_SCAN;
                     scan_cnt_q <= '0;
                  end
               end
               S_SCAN: begin
                  if (drop_rsp) pend_q[rsp_line_q] <= 1'b0;
                  scan_cnt_q <= scan_cnt_q + 1'b1;
                  if (scan_cnt_q == LAST_LINE) st_q <= S_DRAIN;
               end
               S_DRAIN: begin
                  if (drop_rsp) pend_q[rsp_line_q] <= 1'b0;
                  st_q <= S_FIN;
               end
               S_FIN: begin
                  if (pend_q != '0) begin
                     dr_cnt_q <= DR_LOAD;
                     or2_q    <= pack_or2(3'(pend_cnt), 1'b1);
                     st_q     <= S_WAIT;
                  end else begin
                     st_q <= S_IDLE;
                  end
               end
               S_WAIT: begin
                  if (or2_adv) begin
                     if (pick_any) begin
                        cur_line_q <= pick_idx;
                        st_q       <= S_FETCH;
                     end else begin
                        st_q <= S_IDLE;
                     end
                  end
               end
               S_FETCH: begin
                  if (!short_busy) st_q <= S_CAP;
               end
               S_CAP: begin
                  or1_q              <= sm_rd_data;
                  or2_q              <= pack_or2(3'(cur_line_q), pick_rest);
                  pend_q[cur_line_q] <= 1'b0;
                  st_q               <= S_WAIT;
               end
               default: st_q <= S_IDLE;
            endcase
         end
      end
   end

   assign dr_n = (dr_cnt_q == '0);
   assign or1  = or1_q;
   assign or2  = or2_q;
endmodule

// File: rtl/sigx_chk.sv
`timescale 1ns/1ps
module sigx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mask_wr,
   input logic [7:0] mask_data,
   input logic       short_busy,
   input logic       sm_rd_en,
   input logic       dr_n,
   input logic [7:0] or1,
   input logic [7:0] or2
);
   // R2: a mask store leaves the message register alone
   p_or1_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> $stable(or1));

   // R3: an all-zero mask reports zero lines, inactive
   p_zero_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr && mask_data == 8'h00) |=> (or2 == 8'h0E));

   // R5: the interrupt lasts at least two clocks
   p_dr_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dr_n) |=> !dr_n);

   // R5: the announcement carries the active flag
   p_dr_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dr_n) |-> or2[4]);

   // R11: no memory access starts while a short command holds the memory
   p_no_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sm_rd_en) |-> (!short_busy || !$past(short_busy)));
endmodule

bind sig_slot_extractor sigx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_data(8'(mask_data)),
   .short_busy(short_busy), .sm_rd_en(sm_rd_en), .dr_n(dr_n), .or1(or1), .or2(or2)
);

// File: tb/sig_slot_extractor_tb_top.sv
`timescale 1ns/1ps
module sig_slot_extractor_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mask_wr = 1'b0;
   logic [7:0] mask_data = 8'h00;
   logic       frame_stb = 1'b0;
   logic       short_busy = 1'b0;
   logic       sm_rd_en;
   logic [2:0] sm_rd_line;
   logic [7:0] sm_rd_data = 8'h00;
   logic       rd_stb = 1'b0;
   logic       rd_sel = 1'b0;
   logic       dr_n;
   logic [7:0] or1, or2;
   logic       ext_busy;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [7:0] slot0 [8];
   int rd_cnt = 0;
   logic [2:0] rd_log [16];

   always #10 clk = ~clk;

   sig_slot_extractor dut_i (
      .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_data(mask_data),
      .frame_stb(frame_stb), .short_busy(short_busy), .sm_rd_en(sm_rd_en),
      .sm_rd_line(sm_rd_line), .sm_rd_data(sm_rd_data), .rd_stb(rd_stb),
      .rd_sel(rd_sel), .dr_n(dr_n), .or1(or1), .or2(or2), .ext_busy(ext_busy)
   );

   // speech-memory slot-0 model, one clock latency
   always @(posedge clk) begin
      if (sm_rd_en) begin
         sm_rd_data <= slot0[sm_rd_line];
         rd_log[rd_cnt % 16] <= sm_rd_line;
         rd_cnt <= rd_cnt + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
      n_chk++;
      if (act !== exp_v) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
      end
   endtask

   task automatic store_mask(input logic [7:0] m);
      @(negedge clk); mask_wr = 1'b1; mask_data = m;
      @(negedge clk); mask_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic sel);
      @(negedge clk); rd_stb = 1'b1; rd_sel = sel;
      @(negedge clk); rd_stb = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   // watches 20 falling edges; k=1 is the one after the first rising edge
   task automatic watch(output int first, output int lows);
      first = 0; lows = 0;
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         if (!dr_n) begin
            lows++;
            if (first == 0) first = k;
         end
      end
   endtask

   task automatic frame(output int first, output int lows, output int reads);
      int base;
      base = rd_cnt;
      @(negedge clk); frame_stb = 1'b1;
      @(negedge clk); frame_stb = 1'b0;
      watch(first, lows);
      reads = rd_cnt - base;
   endtask

   task automatic t_reset();
      int f, l, r;
      chk("R1 dr_n", 32'(dr_n), 1);
      chk("R1 or1", 32'(or1), 32'h00);
      chk("R1 or2", 32'(or2), 32'h0E);
      chk("R1 sm_rd_en", 32'(sm_rd_en), 0);
      frame(f, l, r);
      chk("R1 no dr before mask", 32'(l), 0);
      chk("R1 no reads before mask", 32'(r), 0);
   endtask

   task automatic t_mask();
      int f, l, r;
      store_mask(8'hA5);
      chk("R2 or2 after A5", 32'(or2), 32'h9E);
      chk("R2 or1 untouched", 32'(or1), 32'h00);
      store_mask(8'hFF);
      chk("R2 or2 eight lines", 32'(or2), 32'h1E);
      store_mask(8'h00);
      chk("R3 or2 zero mask", 32'(or2), 32'h0E);
      frame(f, l, r);
      chk("R3 no dr", 32'(l), 0);
      chk("R3 no reads", 32'(r), 0);
   endtask

   task automatic t_extract();
      int f, l, r, base;
      store_mask(8'hB6);
      chk("R2 or2 after B6", 32'(or2), 32'hBE);
      base = rd_cnt;
      frame(f, l, r);
      chk("R5 dr latency", 32'(f), 11);
      chk("R5 dr width", 32'(l), 2);
      chk("R4 read count", 32'(r), 8);
      for (int i = 0; i < 8; i++)
         chk("R4 read order", 32'(rd_log[(base + i) % 16]), 32'(i));
      chk("R4 R5 announced count", 32'(or2), 32'h7E);
      rd_reg(1'b1);
      chk("R6 R7 first msg", 32'(or1), 32'h81);
      chk("R6 R7 first line", 32'(or2), 32'hFE);
      rd_reg(1'b1);
      chk("R8 repeated or2 read or1", 32'(or1), 32'h81);
      chk("R8 repeated or2 read or2", 32'(or2), 32'hFE);
      rd_reg(1'b0);
      rd_reg(1'b0);
      chk("R8 or1 reads keep or2", 32'(or2), 32'hFE);
      rd_reg(1'b1);
      chk("R7 second msg", 32'(or1), 32'hC3);
      chk("R7 second line", 32'(or2), 32'h9E);
      rd_reg(1'b0);
      rd_reg(1'b1);
      chk("R6 last msg", 32'(or1), 32'h12);
      chk("R6 last line no more", 32'(or2), 32'h4E);
      base = rd_cnt;
      rd_reg(1'b0);
      rd_reg(1'b1);
      chk("R9 or1 after end", 32'(or1), 32'h12);
      chk("R9 or2 after end", 32'(or2), 32'h4E);
      chk("R9 no read after end", 32'(rd_cnt - base), 0);
   endtask

   task automatic t_restart();
      int f, l, r;
      frame(f, l, r);
      chk("R10 first announce", 32'(or2), 32'h7E);
      rd_reg(1'b1);
      chk("R10 step before restart", 32'(or2), 32'hFE);
      frame(f, l, r);
      chk("R10 restart dr latency", 32'(f), 11);
      chk("R10 restart announce", 32'(or2), 32'h7E);
      rd_reg(1'b1);
      chk("R10 restart msg", 32'(or1), 32'h81);
      chk("R10 restart line", 32'(or2), 32'hFE);
   endtask

   task automatic t_none();
      int f, l, r;
      store_mask(8'h22);
      chk("R2 or2 after 22", 32'(or2), 32'h5E);
      frame(f, l, r);
      chk("R5 no dr when all idle", 32'(l), 0);
      chk("R5 or2 kept when none", 32'(or2), 32'h5E);
      chk("R4 reads when none", 32'(r), 8);
   endtask

   task automatic t_busy();
      int f, l, base;
      store_mask(8'hB6);
      @(negedge clk); short_busy = 1'b1;
      base = rd_cnt;
      @(negedge clk); frame_stb = 1'b1;
      @(negedge clk); frame_stb = 1'b0;
      for (int k = 0; k < 8; k++) @(negedge clk);
      chk("R11 no reads while busy", 32'(rd_cnt - base), 0);
      chk("R11 no dr while busy", 32'(dr_n), 1);
      short_busy = 1'b0;
      watch(f, l);
      chk("R11 dr after release", 32'(f), 11);
      chk("R11 reads after release", 32'(rd_cnt - base), 8);
      chk("R11 announce", 32'(or2), 32'h7E);
   endtask

   initial begin
      slot0[0] = 8'h99; slot0[1] = 8'h7F; slot0[2] = 8'h12; slot0[3] = 8'h5A;
      slot0[4] = 8'hC3; slot0[5] = 8'h45; slot0[6] = 8'h00; slot0[7] = 8'h81;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_extract();
      t_restart();
      t_none();
      t_busy();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule